// File: doc/BRIEF.md
# Key Combination Detector with Precondition

This block watches five debounced, active-low inputs: three keyboard keys, the power button and the AC-present line. It runs four detectors side by side. Each detector can first require an optional set of "precondition" inputs to be held down for a programmed number of cycles. Only then is it armed. An armed detector then waits for its chosen "combo" inputs to become pressed together. The combo must stay held for a second programmed number of cycles, after which the detector fires once.

A firing detector triggers the actions enabled in its own four-bit action mask. The actions are a sticky battery-disable output, a per-detector interrupt status bit, an active-low embedded-controller reset pulse of programmable width, and a single-cycle system reset request. The outputs of all detectors are merged. Debouncing happens upstream. Configuration arrives on plain input ports that a register bank elsewhere drives.

Top module: `keycombo_detect`

## Requirements
- R1: Every five-bit selection field uses bit 0 for key0, bit 1 for key1, bit 2 for key2, bit 3 for the power button and bit 4 for AC-present. An input reads as pressed when its level on `keys_i` is 0.
- R2: A detector with an empty precondition selection is armed one cycle after it is enabled, with no precondition timing.
- R3: A detector whose combo selection is zero never fires.
- R4: With a non-empty precondition of time T, the selected precondition inputs must stay pressed through the T+2 rising edges that follow their press before the detector is armed. A combo that is already complete when arming happens does not fire.
- R5: An armed detector with detection time D fires at the (D+2)-th rising edge after all its combo inputs become pressed, provided they stay pressed. Its action outputs change at that same edge.
- R6: Releasing any selected precondition or combo input before the running timer expires returns the detector to idle with no action. Timing then restarts on the next press.
- R7: After firing, a detector does not fire again until all of its combo inputs have been released.
- R8: Action bit 0 sets `bat_disable_o`, which then stays high until reset.
- R9: Action bit 3 makes `rst_req_o` high for exactly one cycle per firing.
- R10: Action bit 2 drives `ec_rst_no` low for exactly `pulse_width_i` cycles, starting at the firing edge. A width of 0 gives no pulse.
- R11: A detector's status bit is set only when it fires with action bit 1 enabled. The bit is cleared by a 1 on its `status_clr_i` bit. `intr_o` is the OR of all status bits.
- R12: The four detectors are independent: one firing leaves the others' outputs untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (timer step) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| keys_i | input | 5 | Debounced inputs, 0 = pressed |
| pre_sel_i | input | 20 | Precondition selection, 5 bits per detector |
| pre_time_i | input | 128 | Precondition hold time, 32 bits per detector |
| combo_sel_i | input | 20 | Combo selection, 5 bits per detector |
| det_time_i | input | 128 | Combo hold time, 32 bits per detector |
| act_mask_i | input | 16 | Action mask, 4 bits per detector |
| pulse_width_i | input | 16 | Reset pulse width in cycles |
| status_clr_i | input | 4 | Write-1-to-clear strobe for status bits |
| bat_disable_o | output | 1 | Sticky battery disable |
| intr_o | output | 1 | Interrupt request |
| ec_rst_no | output | 1 | Active-low embedded-controller reset |
| rst_req_o | output | 1 | One-cycle system reset request |
| status_o | output | 4 | Per-detector interrupt status |

## Verification
The assertions run on every cycle. They check that a detector with no combo selection never fires, and that no detector fires on two cycles in a row. They also check that every change of an action output traces back to a firing whose mask enables that action: the battery disable stays set, the reset request follows firing by one cycle, and the reset pulse and the status bits start only after a matching firing. Exact cycle counts need the bench's directed scenarios. These are the arming boundary of the precondition, the (D+2)-edge firing latency, the width of the reset pulse, restart after an early release, and refusal to fire again while keys stay held.

// File: rtl/kcd_pkg.sv
package kcd_pkg;

  typedef enum logic [2:0] {
    DET_IDLE  = 3'd0,
    DET_PRE   = 3'd1,
    DET_ARMED = 3'd2,
    DET_HOLD  = 3'd3,
    DET_DONE  = 3'd4
  } det_state_e;

  // action mask bit positions
  localparam int ACT_BAT  = 0;
  localparam int ACT_INTR = 1;
  localparam int ACT_EC   = 2;
  localparam int ACT_RST  = 3;
  localparam int ACT_W    = 4;

endpackage

// File: rtl/kcd_detector.sv
module kcd_detector
  import kcd_pkg::*;
#(
  parameter int NUM_KEYS = 5,
  parameter int TIMER_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic [NUM_KEYS-1:0] pre_sel_i,
  input  logic [TIMER_W-1:0]  pre_time_i,
  input  logic [NUM_KEYS-1:0] combo_sel_i,
  input  logic [TIMER_W-1:0]  det_time_i,
  output logic                fire_o
);

  logic [NUM_KEYS-1:0] pressed;
  logic pre_empty, pre_held;
  logic combo_en, combo_all, combo_none, combo_rise;

  det_state_e         state_q, state_d;
  logic [TIMER_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;
  logic               combo_q;

  always_comb begin
    pressed    = ~keys_i;
    pre_empty  = (pre_sel_i == '0);
    pre_held   = ((pressed & pre_sel_i) == pre_sel_i);
    combo_en   = (combo_sel_i != '0);
    combo_all  = combo_en && ((pressed & combo_sel_i) == combo_sel_i);
    combo_none = ((pressed & combo_sel_i) == '0);
    combo_rise = combo_all && !combo_q;
  end

  // next-state logic; one counter serves both timed phases
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    fire_o  = 1'b0;
    if (!combo_en) begin
      state_d = DET_IDLE;
      cnt_d   = '0;
      cnt_en  = (cnt_q != '0);
    end else begin
      case (state_q)
        DET_IDLE: begin
          cnt_d  = '0;
          cnt_en = (cnt_q != '0);
          if (pre_held) begin
            state_d = pre_empty ? DET_ARMED : DET_PRE;
          end
        end
        DET_PRE: begin
          if (!pre_held) begin
            state_d = DET_IDLE;
          end else begin
            cnt_en = 1'b1;
            if (cnt_q == pre_time_i) begin
              state_d = DET_ARMED;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        DET_ARMED: begin
          if (!pre_held) begin
            state_d = DET_IDLE;
          end else if (combo_rise) begin
            state_d = DET_HOLD;
            cnt_d   = '0;
            cnt_en  = 1'b1;
          end
        end
        DET_HOLD: begin
          if (!pre_held || !combo_all) begin
            state_d = DET_IDLE;
          end else begin
            cnt_en = 1'b1;
            if (cnt_q == det_time_i) begin
              state_d = DET_DONE;
              fire_o  = 1'b1;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        DET_DONE: begin
          if (combo_none) begin
            state_d = DET_IDLE;
          end
        end
        default: state_d = DET_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DET_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // history resets to "complete" so a combo held through reset needs a release first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      combo_q <= 1'b1;
    end else begin
      combo_q <= combo_all;
    end
  end

endmodule

// File: rtl/kcd_pulse_stretch.sv
module kcd_pulse_stretch #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [WIDTH-1:0] width_i,
  output logic             pulse_no
);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = trig_i || (cnt_q != '0);
    cnt_d  = trig_i ? width_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pulse_no = (cnt_q == '0);

endmodule

// File: rtl/kcd_actions.sv
module kcd_actions
  import kcd_pkg::*;
#(
  parameter int NUM_DET = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_DET-1:0]       fire_i,
  input  logic [NUM_DET*ACT_W-1:0] act_mask_i,
  input  logic [NUM_DET-1:0]       status_clr_i,
  output logic                     bat_disable_o,
  output logic                     rst_req_o,
  output logic                     ec_trig_o,
  output logic [NUM_DET-1:0]       status_o,
  output logic                     intr_o
);

  logic [NUM_DET-1:0] bat_hit, intr_hit, ec_hit, rst_hit;
  logic [NUM_DET-1:0] status_q, status_d;
  logic               status_en;
  logic               bat_q, bat_en;
  logic               rst_q;

  for (genvar i = 0; i < NUM_DET; i++) begin : g_hit
    assign bat_hit[i]  = fire_i[i] & act_mask_i[i*ACT_W + ACT_BAT];
    assign intr_hit[i] = fire_i[i] & act_mask_i[i*ACT_W + ACT_INTR];
    assign ec_hit[i]   = fire_i[i] & act_mask_i[i*ACT_W + ACT_EC];
    assign rst_hit[i]  = fire_i[i] & act_mask_i[i*ACT_W + ACT_RST];
  end

  always_comb begin
    status_d  = (status_q & ~status_clr_i) | intr_hit;
    status_en = (status_clr_i != '0) || (intr_hit != '0);
    bat_en    = |bat_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bat_q <= 1'b0;
    end else if (bat_en) begin
      bat_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
    end else begin
      rst_q <= |rst_hit;
    end
  end

  assign ec_trig_o     = |ec_hit;
  assign bat_disable_o = bat_q;
  assign rst_req_o     = rst_q;
  assign status_o      = status_q;
  assign intr_o        = |status_q;

endmodule

// File: rtl/keycombo_detect.sv
module keycombo_detect
  import kcd_pkg::*;
#(
  parameter int NUM_DET  = 4,
  parameter int NUM_KEYS = 5,
  parameter int TIMER_W  = 32,
  parameter int PULSE_W  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_KEYS-1:0]         keys_i,
  input  logic [NUM_DET*NUM_KEYS-1:0] pre_sel_i,
  input  logic [NUM_DET*TIMER_W-1:0]  pre_time_i,
  input  logic [NUM_DET*NUM_KEYS-1:0] combo_sel_i,
  input  logic [NUM_DET*TIMER_W-1:0]  det_time_i,
  input  logic [NUM_DET*ACT_W-1:0]    act_mask_i,
  input  logic [PULSE_W-1:0]          pulse_width_i,
  input  logic [NUM_DET-1:0]          status_clr_i,
  output logic                        bat_disable_o,
  output logic                        intr_o,
  output logic                        ec_rst_no,
  output logic                        rst_req_o,
  output logic [NUM_DET-1:0]          status_o
);

  logic [NUM_DET-1:0] det_fire;
  logic               ec_trig;

  for (genvar i = 0; i < NUM_DET; i++) begin : g_det
    kcd_detector #(
      .NUM_KEYS (NUM_KEYS),
      .TIMER_W  (TIMER_W)
    ) u_det (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .keys_i      (keys_i),
      .pre_sel_i   (pre_sel_i[i*NUM_KEYS +: NUM_KEYS]),
      .pre_time_i  (pre_time_i[i*TIMER_W +: TIMER_W]),
      .combo_sel_i (combo_sel_i[i*NUM_KEYS +: NUM_KEYS]),
      .det_time_i  (det_time_i[i*TIMER_W +: TIMER_W]),
      .fire_o      (det_fire[i])
    );
  end

  kcd_actions #(
    .NUM_DET (NUM_DET)
  ) u_act (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fire_i        (det_fire),
    .act_mask_i    (act_mask_i),
    .status_clr_i  (status_clr_i),
    .bat_disable_o (bat_disable_o),
    .rst_req_o     (rst_req_o),
    .ec_trig_o     (ec_trig),
    .status_o      (status_o),
    .intr_o        (intr_o)
  );

  kcd_pulse_stretch #(
    .WIDTH (PULSE_W)
  ) u_ec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (ec_trig),
    .width_i  (pulse_width_i),
    .pulse_no (ec_rst_no)
  );

endmodule

// File: rtl/kcd_checker.sv
module kcd_checker
  import kcd_pkg::*;
#(
  parameter int NUM_DET  = 4,
  parameter int NUM_KEYS = 5
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_DET-1:0]          fire_i,
  input logic [NUM_DET*NUM_KEYS-1:0] combo_sel_i,
  input logic [NUM_DET*ACT_W-1:0]    act_mask_i,
  input logic                        bat_disable_i,
  input logic                        rst_req_i,
  input logic                        ec_rst_ni,
  input logic [NUM_DET-1:0]          status_i
);

  logic [NUM_DET-1:0] bat_fire, ec_fire, rst_fire;

  for (genvar i = 0; i < NUM_DET; i++) begin : g_chk
    assign bat_fire[i] = fire_i[i] & act_mask_i[i*ACT_W + ACT_BAT];
    assign ec_fire[i]  = fire_i[i] & act_mask_i[i*ACT_W + ACT_EC];
    assign rst_fire[i] = fire_i[i] & act_mask_i[i*ACT_W + ACT_RST];

    AST_DISABLED_NO_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i[i] |-> (combo_sel_i[i*NUM_KEYS +: NUM_KEYS] != '0)); // R3

    AST_NO_BACK_TO_BACK_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i[i] |=> !fire_i[i]); // R7

    AST_STATUS_NEEDS_INTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_i[i]) |-> $past(fire_i[i] && act_mask_i[i*ACT_W + ACT_INTR])); // R11
  end

  AST_BAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_disable_i |=> bat_disable_i); // R8

  AST_BAT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bat_disable_i) |-> $past(|bat_fire)); // R8

  AST_RST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i == $past(|rst_fire)); // R9

  AST_EC_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ec_rst_ni) |-> $past(|ec_fire)); // R10

endmodule

bind keycombo_detect kcd_checker #(
  .NUM_DET  (NUM_DET),
  .NUM_KEYS (NUM_KEYS)
) u_kcd_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fire_i        (det_fire),
  .combo_sel_i   (combo_sel_i),
  .act_mask_i    (act_mask_i),
  .bat_disable_i (bat_disable_o),
  .rst_req_i     (rst_req_o),
  .ec_rst_ni     (ec_rst_no),
  .status_i      (status_o)
);

// File: tb/keycombo_detect_tb_top.sv
module keycombo_detect_tb_top;

  localparam int ND = 4;
  localparam int NK = 5;
  localparam int TW = 32;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic [NK-1:0]  keys;
  logic [ND*NK-1:0] pre_sel, combo_sel;
  logic [ND*TW-1:0] pre_time, det_time;
  logic [ND*4-1:0]  act_mask;
  logic [15:0]      pulse_width;
  logic [ND-1:0]    status_clr;
  logic             bat_disable_o, intr_o, ec_rst_no, rst_req_o;
  logic [ND-1:0]    status_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk_i = ~clk_i;

  keycombo_detect dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .keys_i        (keys),
    .pre_sel_i     (pre_sel),
    .pre_time_i    (pre_time),
    .combo_sel_i   (combo_sel),
    .det_time_i    (det_time),
    .act_mask_i    (act_mask),
    .pulse_width_i (pulse_width),
    .status_clr_i  (status_clr),
    .bat_disable_o (bat_disable_o),
    .intr_o        (intr_o),
    .ec_rst_no     (ec_rst_no),
    .rst_req_o     (rst_req_o),
    .status_o      (status_o)
  );

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    pre_sel = '0; combo_sel = '0; pre_time = '0; det_time = '0; act_mask = '0;
    keys = '1;
    tick(3);
  endtask

  task automatic cfg(input int d, input logic [4:0] ps, input logic [31:0] pt,
                     input logic [4:0] cs, input logic [31:0] dt, input logic [3:0] am);
    pre_sel[d*NK +: NK]   = ps;
    pre_time[d*TW +: TW]  = pt;
    combo_sel[d*NK +: NK] = cs;
    det_time[d*TW +: TW]  = dt;
    act_mask[d*4 +: 4]    = am;
  endtask

  task automatic count_rst(input int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (rst_req_o) hits++;
    end
  endtask

  task automatic t_reset();
    check(bat_disable_o == 1'b0, "R8 reset bat", bat_disable_o, 0);
    check(rst_req_o == 1'b0, "R9 reset rst_req", rst_req_o, 0);
    check(ec_rst_no == 1'b1, "R10 reset ec_rst_n", ec_rst_no, 1);
    check(status_o == '0 && intr_o == 1'b0, "R11 reset status", {intr_o, status_o}, 0);
  endtask

  task automatic t_disabled();
    int hits;
    clear_cfg();
    act_mask = '1;
    tick(2);
    keys = 5'b00000;
    count_rst(20, hits);
    check(hits == 0 && !bat_disable_o && ec_rst_no && status_o == '0,
          "R3 empty combo fires nothing", hits, 0);
    keys = '1;
    tick(3);
  endtask

  task automatic t_basic_timing();
    logic [5:0] seen;
    clear_cfg();
    cfg(0, 5'b00000, 0, 5'b00110, 3, 4'b1000);  // R1 key1=bit1, key2=bit2
    tick(3);
    keys = 5'b11101;
    tick(3);
    check(rst_req_o == 1'b0, "R1 partial combo no fire", rst_req_o, 0);
    keys = 5'b11001;
    for (int k = 1; k <= 6; k++) begin
      tick();
      seen[k-1] = rst_req_o;
    end
    check(seen == 6'b010000, "R5 R2 fire at edge D+2 single pulse R9", seen, 6'b010000);
    check(status_o == '0 && !bat_disable_o && ec_rst_no, "R11 masked actions idle",
          {bat_disable_o, status_o}, 0);
    keys = '1;
    tick(3);
  endtask

  task automatic t_release_early();
    int hits;
    clear_cfg();
    cfg(0, 5'b00000, 0, 5'b00110, 10, 4'b1000);
    tick(3);
    keys = 5'b11001;
    tick(5);
    keys = 5'b11101;
    count_rst(20, hits);
    check(hits == 0, "R6 early release no fire", hits, 0);
    keys = 5'b11001;
    count_rst(11, hits);
    check(hits == 0, "R6 timer restarted", hits, 0);
    count_rst(1, hits);
    check(hits == 1, "R6 fires after full restart", hits, 1);
    keys = '1;
    tick(3);
  endtask

  task automatic t_no_rearm();
    int hits;
    clear_cfg();
    cfg(0, 5'b00000, 0, 5'b00110, 2, 4'b1000);
    tick(3);
    keys = 5'b11001;
    count_rst(10, hits);
    check(hits == 1, "R7 first fire", hits, 1);
    count_rst(20, hits);
    check(hits == 0, "R7 held no refire", hits, 0);
    keys = 5'b11011;
    tick(3);
    keys = 5'b11001;
    count_rst(10, hits);
    check(hits == 0, "R7 partial release no refire", hits, 0);
    keys = '1;
    tick(3);
    keys = 5'b11001;
    count_rst(10, hits);
    check(hits == 1, "R7 refire after full release", hits, 1);
    keys = '1;
    tick(3);
  endtask

  task automatic t_precondition();
    clear_cfg();
    cfg(1, 5'b01000, 6, 5'b00001, 2, 4'b0001);
    tick(3);
    keys = 5'b10110;
    tick(30);
    check(!bat_disable_o, "R4 combo held at arming no fire", bat_disable_o, 0);
    keys = '1; tick(3);
    keys = 5'b10111;
    tick(7);
    keys = 5'b10110;
    tick(20);
    check(!bat_disable_o, "R4 combo one edge early no fire", bat_disable_o, 0);
    keys = '1; tick(3);
    keys = 5'b10111; tick(4);
    keys = '1; tick(1);
    keys = 5'b10111; tick(7);
    keys = 5'b10110;
    tick(20);
    check(!bat_disable_o, "R6 precondition release restarts", bat_disable_o, 0);
    keys = '1; tick(3);
    keys = 5'b10111;
    tick(8);
    keys = 5'b10110;
    tick(3);
    check(!bat_disable_o, "R4 before D+2", bat_disable_o, 0);
    tick(1);
    check(bat_disable_o, "R4 R5 fire after arming", bat_disable_o, 1);
    keys = '1;
    tick(5);
    check(bat_disable_o, "R8 battery disable sticky", bat_disable_o, 1);
  endtask

  task automatic t_ec_pulse();
    bit always_high;
    clear_cfg();
    cfg(2, 5'b00000, 0, 5'b10000, 1, 4'b0100);  // R1 AC-present = bit4
    pulse_width = 16'd5;
    tick(3);
    keys = 5'b01111;
    tick(2);
    check(ec_rst_no, "R10 before fire", ec_rst_no, 1);
    tick(1);
    check(!ec_rst_no, "R10 pulse starts", ec_rst_no, 0);
    tick(4);
    check(!ec_rst_no, "R10 pulse last cycle", ec_rst_no, 0);
    tick(1);
    check(ec_rst_no, "R10 pulse ends after width", ec_rst_no, 1);
    keys = '1;
    pulse_width = 16'd0;
    tick(3);
    keys = 5'b01111;
    always_high = 1'b1;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (!ec_rst_no) always_high = 1'b0;
    end
    check(always_high, "R10 zero width no pulse", always_high, 1);
    keys = '1;
    tick(3);
  endtask

  task automatic t_status();
    int hits;
    clear_cfg();
    cfg(3, 5'b00000, 0, 5'b00001, 1, 4'b0010);
    cfg(0, 5'b00000, 0, 5'b00010, 1, 4'b1000);
    tick(3);
    keys = 5'b11110;
    count_rst(3, hits);
    check(status_o == 4'b1000 && intr_o, "R11 status set by intr action",
          {intr_o, status_o}, 5'b11000);
    check(hits == 0, "R12 other detector untouched", hits, 0);
    status_clr = 4'b1000;
    tick(1);
    status_clr = '0;
    check(status_o == '0 && !intr_o, "R11 write-1 clear", {intr_o, status_o}, 0);
    keys = 5'b11100;
    count_rst(6, hits);
    check(hits == 1 && status_o == '0, "R12 R11 second detector fires, no status",
          {hits[3:0], status_o}, 8'h10);
    keys = '1;
    tick(3);
  endtask

  initial begin
    rst_ni      = 1'b0;
    keys        = '1;
    pre_sel     = '0; combo_sel = '0; pre_time = '0; det_time = '0; act_mask = '0;
    pulse_width = 16'd5;
    status_clr  = '0;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    t_reset();
    t_disabled();
    t_basic_timing();
    t_release_early();
    t_no_rearm();
    t_ec_pulse();
    t_status();
    t_precondition();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule